// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the register-programming front end of a classic eight-input interrupt controller. It accepts byte writes on two ports, a command port and a data port, and turns them into the controller's configuration state: the interrupt vector base, the eight-bit input mask and the automatic end-of-interrupt flag. It follows the multi-word initialization handshake. A command-port start word arms the sequence. The data-port writes after it are then read as the vector base, the cascade word and, if the start word asked for it, a mode word. Once the sequence completes, data-port writes load the mask register.

Command-port writes outside the start word are classified as one of two operation words. The end-of-interrupt form is forwarded to the priority logic as a one-cycle strobe with its three-bit level field. The register-select form is accepted, and its poll request is refused. Each mode the block does not implement produces a one-cycle error pulse and leaves all stored state alone: single-controller operation, four-byte vector spacing, level triggering, the 8-bit-processor call formats, poll, non-x86 processor mode and special fully nested mode. A combinational output forms the full vector for any input number from the stored base.

All registered outputs change on the rising clock edge that captures the write.

Top module: `icw_sequencer`

## Requirements
- R1: After reset, irq_mask is 8'hFF, vec_base is 0, auto_eoi is 0, in_init is 0, and mode_err and eoi_stb are low.
- R2: A command-port write (wr_port=0) with bit 4 set and bits 1, 2, 3 and 7:5 all clear is a start word. It sets in_init and clears auto_eoi. The next data-port write (wr_port=1) stores its bits 7:3 as vec_base.
- R3: A start word with bit 0 clear ends the sequence with the second data write, which is the cascade word. With bit 0 set, a third data write, the mode word, is expected. in_init falls after the last expected word.
- R4: A start word with any of bits 1, 2, 3, 7, 6 or 5 set pulses mode_err for one cycle and changes no stored state, including the sequence position.
- R5: A mode word with bit 0 set and bit 4 clear loads auto_eoi from its bit 1. A mode word with bit 0 clear or bit 4 set pulses mode_err, leaves auto_eoi unchanged and keeps waiting for a mode word.
- R6: While in_init is low, a data-port write loads irq_mask with the written byte (a 1 masks the input). Data writes during initialization never change irq_mask.
- R7: A command-port write with bit 4 clear and bit 3 set is a register-select word. With bit 2 set it pulses mode_err. Otherwise it has no visible effect.
- R8: A command-port write with bits 4 and 3 both clear raises eoi_stb for one cycle and sets eoi_level to its bits 2:0. It does not touch the sequence or the stored registers.
- R9: vector equals {vec_base, irq_sel} at all times.
- R10: In a cycle with wr_en low, no stored state changes and neither pulse output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_port | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Written byte |
| irq_sel | input | 3 | Input number for vector lookup |
| vector | output | 8 | Vector for irq_sel |
| vec_base | output | 5 | Stored vector base |
| irq_mask | output | 8 | Mask register, 1 = masked |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| in_init | output | 1 | Initialization sequence in progress |
| eoi_stb | output | 1 | One-cycle end-of-interrupt command strobe |
| eoi_level | output | 3 | Level field of the last end-of-interrupt command |
| mode_err | output | 1 | One-cycle unsupported-mode pulse |

## Verification
The assertions check on every cycle that state holds still whenever an error is reported, and that the mask, the vector base and the auto-EOI flag each change only on the write kind and sequence position allowed to change them. They also check that the end-of-interrupt strobe follows only the matching command and that the mode-word position is reached only when the start word asked for it. Only the bench scenarios can show that the right byte fields land in the right registers, that the two- and three-word sequence lengths end on the correct write, and that an interrupted or erroneous sequence resumes correctly.

// File: rtl/icw_seq_pkg.sv
package icw_seq_pkg;

    typedef enum logic [1:0] {
        ST_MASK = 2'd0,
        ST_ICW2 = 2'd1,
        ST_ICW3 = 2'd2,
        ST_ICW4 = 2'd3
    } seq_st_e;

    typedef enum logic [2:0] {
        WK_NONE = 3'd0,
        WK_ICW1 = 3'd1,
        WK_OCW2 = 3'd2,
        WK_OCW3 = 3'd3,
        WK_DATA = 3'd4
    } wr_kind_e;

endpackage

// File: rtl/icw_wr_decoder.sv
module icw_wr_decoder
    import icw_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          wr_en,
    input  logic          wr_port,
    input  logic [DW-1:0] wr_data,
    output wr_kind_e      kind,
    output logic          icw1_bad,
    output logic          ocw3_poll,
    output logic          icw4_bad
);
    // Classify a write; command port decodes on bits 4 and 3.
    always_comb begin
        kind = WK_NONE;
        if (wr_en) begin
            if (wr_port)         kind = WK_DATA;
            else if (wr_data[4]) kind = WK_ICW1;
            else if (wr_data[3]) kind = WK_OCW3;
            else                 kind = WK_OCW2;
        end
    end

    // Unsupported features: single, interval-4, level, 8080 call bits.
    assign icw1_bad  = wr_data[1] | wr_data[2] | wr_data[3] | (|wr_data[7:5]);
    assign ocw3_poll = wr_data[2];
    // Mode word: non-x86 processor or special fully nested.
    assign icw4_bad  = ~wr_data[0] | wr_data[4];

endmodule

// File: rtl/icw_init_seq.sv
module icw_init_seq
    import icw_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NUM_IN = 8,
    localparam int LVL_W  = $clog2(NUM_IN),
    localparam int BASE_W = DW - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DW-1:0]     wr_data,
    input  logic              icw1_bad,
    input  logic              ocw3_poll,
    input  logic              icw4_bad,
    output logic [BASE_W-1:0] base,
    output logic [DW-1:0]     mask,
    output logic              aeoi,
    output logic              busy,
    output logic              err,
    output logic              eoi,
    output logic [LVL_W-1:0]  lvl
);
    typedef struct packed {
        seq_st_e           st;
        logic              need4;
        logic [BASE_W-1:0] base;
        logic [DW-1:0]     mask;
        logic              aeoi;
        logic              err;
        logic              eoi;
        logic [LVL_W-1:0]  lvl;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        r_d.eoi = 1'b0;
        case (kind)
            WK_ICW1: begin
                if (icw1_bad) begin
                    r_d.err = 1'b1;
                end else begin
                    r_d.st    = ST_ICW2;
                    r_d.need4 = wr_data[0];
                    r_d.aeoi  = 1'b0;
                end
            end
            WK_OCW3: begin
                if (ocw3_poll) r_d.err = 1'b1;
            end
            WK_OCW2: begin
                r_d.eoi = 1'b1;
                r_d.lvl = wr_data[LVL_W-1:0];
            end
            WK_DATA: begin
                case (r_q.st)
                    ST_MASK: r_d.mask = wr_data;
                    ST_ICW2: begin
                        r_d.base = wr_data[DW-1:LVL_W];
                        r_d.st   = ST_ICW3;
                    end
                    ST_ICW3: r_d.st = r_q.need4 ? ST_ICW4 : ST_MASK;
                    ST_ICW4: begin
                        if (icw4_bad) begin
                            r_d.err = 1'b1;
                        end else begin
                            r_d.aeoi = wr_data[1];
                            r_d.st   = ST_MASK;
                        end
                    end
                    default: r_d.st = ST_MASK;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_MASK;
            r_q.need4 <= 1'b0;
            r_q.base  <= '0;
            r_q.mask  <= '1;
            r_q.aeoi  <= 1'b0;
            r_q.err   <= 1'b0;
            r_q.eoi   <= 1'b0;
            r_q.lvl   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base = r_q.base;
    assign mask = r_q.mask;
    assign aeoi = r_q.aeoi;
    assign busy = (r_q.st != ST_MASK);
    assign err  = r_q.err;
    assign eoi  = r_q.eoi;
    assign lvl  = r_q.lvl;

    // R4 / R5 / R7: an error report never coincides with a sequence move
    a_r4_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |-> $stable(r_q.st));

    // R6: mask moves only on a data write in mask mode
    a_r6_mask_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.mask) |-> $past(kind == WK_DATA && r_q.st == ST_MASK));

    // R2: base moves only on the word following a start word
    a_r2_base_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.base) |-> $past(kind == WK_DATA && r_q.st == ST_ICW2));

    // R5: auto-EOI moves only on a start word or a mode word
    a_r5_aeoi_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.aeoi) |-> $past(kind == WK_ICW1 || (kind == WK_DATA && r_q.st == ST_ICW4)));

    // R3: mode-word position only when the start word asked for it
    a_r3_icw4_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ICW4) |-> r_q.need4);

    // R8: strobe only after an end-of-interrupt command
    a_r8_eoi_from_ocw2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.eoi |-> $past(kind == WK_OCW2));

    // R10: idle cycle raises no pulse
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kind == WK_NONE) |-> (!r_q.err && !r_q.eoi));

endmodule

// File: rtl/icw_vector_gen.sv
module icw_vector_gen #(
    parameter int DW     = 8,
    parameter int NUM_IN = 8,
    localparam int LVL_W  = $clog2(NUM_IN),
    localparam int BASE_W = DW - LVL_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [LVL_W-1:0]  sel,
    output logic [DW-1:0]     vec
);
    assign vec = {base, sel};
endmodule

// File: rtl/icw_sequencer.sv
module icw_sequencer
    import icw_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NUM_IN = 8,
    localparam int LVL_W  = $clog2(NUM_IN),
    localparam int BASE_W = DW - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_port,
    input  logic [DW-1:0]     wr_data,
    input  logic [LVL_W-1:0]  irq_sel,
    output logic [DW-1:0]     vector,
    output logic [BASE_W-1:0] vec_base,
    output logic [DW-1:0]     irq_mask,
    output logic              auto_eoi,
    output logic              in_init,
    output logic              eoi_stb,
    output logic [LVL_W-1:0]  eoi_level,
    output logic              mode_err
);
    wr_kind_e kind;
    logic     icw1_bad, ocw3_poll, icw4_bad;

    icw_wr_decoder #(.DW(DW)) u_dec (
        .wr_en     (wr_en),
        .wr_port   (wr_port),
        .wr_data   (wr_data),
        .kind      (kind),
        .icw1_bad  (icw1_bad),
        .ocw3_poll (ocw3_poll),
        .icw4_bad  (icw4_bad)
    );

    icw_init_seq #(.DW(DW), .NUM_IN(NUM_IN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wr_data   (wr_data),
        .icw1_bad  (icw1_bad),
        .ocw3_poll (ocw3_poll),
        .icw4_bad  (icw4_bad),
        .base      (vec_base),
        .mask      (irq_mask),
        .aeoi      (auto_eoi),
        .busy      (in_init),
        .err       (mode_err),
        .eoi       (eoi_stb),
        .lvl       (eoi_level)
    );

    icw_vector_gen #(.DW(DW), .NUM_IN(NUM_IN)) u_vec (
        .base (vec_base),
        .sel  (irq_sel),
        .vec  (vector)
    );

    // R1: pulses are low in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!mode_err && !eoi_stb));

endmodule

// File: tb/sim_icw_sequencer.sv
`timescale 1ns/1ps
module sim_icw_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_port = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] irq_sel = 3'd0;
    logic [7:0] vector;
    logic [4:0] vec_base;
    logic [7:0] irq_mask;
    logic       auto_eoi, in_init, eoi_stb, mode_err;
    logic [2:0] eoi_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    icw_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .irq_sel(irq_sel), .vector(vector),
        .vec_base(vec_base), .irq_mask(irq_mask), .auto_eoi(auto_eoi),
        .in_init(in_init), .eoi_stb(eoi_stb), .eoi_level(eoi_level),
        .mode_err(mode_err)
    );

    // reference model
    int         m_pos = 0;      // 0 idle, 1..3 = waiting for data word n+1
    bit         m_need4 = 0;
    logic [4:0] m_base = 0;
    logic [7:0] m_mask = 8'hFF;
    bit         m_aeoi = 0;
    bit         m_err = 0;
    bit         m_eoi = 0;
    logic [2:0] m_lvl = 0;

    function automatic bit start_bad(logic [7:0] d);
        return d[1] | d[2] | d[3] | d[5] | d[6] | d[7];
    endfunction

    function automatic bit mode_bad(logic [7:0] d);
        return !d[0] || d[4];
    endfunction

    task automatic model(input bit en, input bit port, input logic [7:0] d);
        m_err = 0; m_eoi = 0;
        if (!en) return;
        if (!port) begin
            if (d[4]) begin
                if (start_bad(d)) m_err = 1;
                else begin m_pos = 1; m_need4 = d[0]; m_aeoi = 0; end
            end else if (d[3]) begin
                if (d[2]) m_err = 1;
            end else begin
                m_eoi = 1; m_lvl = d[2:0];
            end
        end else begin
            case (m_pos)
                0: m_mask = d;
                1: begin m_base = d[7:3]; m_pos = 2; end
                2: m_pos = m_need4 ? 3 : 0;
                default: if (mode_bad(d)) m_err = 1;
                         else begin m_aeoi = d[1]; m_pos = 0; end
            endcase
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " mask (R6)"}, irq_mask, m_mask);
        check({tag, " base (R2)"}, vec_base, m_base);
        check({tag, " aeoi (R5)"}, auto_eoi, m_aeoi);
        check({tag, " in_init (R3)"}, in_init, m_pos != 0);
        check({tag, " err (R4)"}, mode_err, m_err);
        check({tag, " eoi_stb (R8)"}, eoi_stb, m_eoi);
        check({tag, " eoi_level (R8)"}, eoi_level, m_lvl);
        check({tag, " vector (R9)"}, vector, {m_base, irq_sel});
    endtask

    task automatic cyc(input string tag, input bit en, input bit port, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_port = port; wr_data = d;
        irq_sel = 3'($urandom_range(0, 7));
        model(en, port, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 mask", irq_mask, 8'hFF);
        check("R1 base", vec_base, 5'd0);
        check("R1 aeoi", auto_eoi, 1'b0);
        check("R1 init", in_init, 1'b0);
        check("R1 pulses", {mode_err, eoi_stb}, 2'b00);

        // R6 mask write when idle
        cyc("R6 mask", 1, 1, 8'h5A);
        // R2/R3 two-word sequence
        cyc("R2 start", 1, 0, 8'h10);
        cyc("R2 base", 1, 1, 8'hA5);
        cyc("R3 last of two", 1, 1, 8'h04);
        cyc("R6 mask again", 1, 1, 8'h33);
        // R3/R5 three-word with auto-EOI
        cyc("R3 start4", 1, 0, 8'h11);
        cyc("R6 no mask in init", 1, 1, 8'h68);
        cyc("R3 cascade", 1, 1, 8'hFF);
        cyc("R5 bad mode nonx86", 1, 1, 8'h02);
        cyc("R5 bad mode sfnm", 1, 1, 8'h13);
        cyc("R5 good mode", 1, 1, 8'h03);
        // R5 start clears auto-EOI
        cyc("R5 clear", 1, 0, 8'h10);
        cyc("R4 bad start mid", 1, 0, 8'h12);
        cyc("R2 base mid", 1, 1, 8'hF8);
        cyc("R3 end", 1, 1, 8'h00);
        // R4 each unsupported start bit
        for (int b = 1; b < 8; b++) begin
            if (b == 4) continue;
            cyc("R4 bad start", 1, 0, 8'h10 | 8'(1 << b));
        end
        // R7 register-select words
        cyc("R7 poll", 1, 0, 8'h0C);
        cyc("R7 plain", 1, 0, 8'h0B);
        // R8 EOI command
        cyc("R8 eoi", 1, 0, 8'h67);
        cyc("R8 eoi2", 1, 0, 8'h21);
        // R10 idle
        cyc("R10 idle", 0, 1, 8'h00);
        cyc("R10 idle cmd", 0, 0, 8'h10);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [7:0] d = 8'($urandom);
            if (sel == 0)      cyc("R10 rnd", 0, d[0], d);
            else if (sel <= 2) cyc("R4 rnd", 1, 0, (d[0] ? (8'h10 | (d & 8'h01)) : d));
            else if (sel == 3) cyc("R8 rnd", 1, 0, d & 8'hE7);
            else if (sel == 4) cyc("R7 rnd", 1, 0, (d & 8'hE7) | 8'h08);
            else if (sel == 5) cyc("R5 rnd", 1, 1, d[7] ? ((d & 8'hEF) | 8'h01) : d);
            else               cyc("R6 rnd", 1, 1, d);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule